// File: doc/BRIEF.md
# Row-Hit-First Request Selector

This block decides which pending memory request a controller should issue next. It looks at a small queue of decoded requests. Each entry carries a rank, a bank inside that rank and a row. Entry 0 is the oldest and higher indices are younger. The block keeps a table with one slot per bank. Each slot holds the row currently open in that bank, a count of column accesses made since the row was opened, and a countdown of cycles until the bank can accept another access.

When `pick` is raised, the block selects one valid entry using the policy on `policy`. It reports the winner one cycle later as a one-cycle grant, together with the flat bank index and whether the access hits the open row. At the same clock edge it updates the granted bank's slot.

The controller is a two-state machine:
- `ST_IDLE` accepts a pick. The transition *take* (pick with at least one valid entry) leads to `ST_GRANT`.
- `ST_GRANT` presents the grant for one cycle. The transition *release* then returns unconditionally to `ST_IDLE`.

Top module: `rowhit_sel`

## Requirements
- R1: With `policy` = 0 (arrival order), the grant goes to the lowest-indexed valid entry, whatever the row and bank state.
- R2: With `policy` = 1 (row-hit-first), an entry qualifies as an available hit when two conditions hold: its row equals its bank's open row, and that bank's countdown is zero. If any entry qualifies, the lowest-indexed available hit wins.
- R3: With `policy` = 1 and no available hit, the block first finds the smallest countdown among the banks named by valid entries. Those banks form a mask, and the lowest-indexed valid entry whose bank is in the mask wins.
- R4: The flat bank index reported on `grant_bank` is rank × `BPR` + bank; with `BPR` = 4, rank 1 bank 1 is index 5. Banks with different flat indices keep separate state.
- R5: After reset every bank is closed (open row held at the all-ones reserved value) with a zero countdown. A granted miss opens the requested row, and `grant_hit` is 1 exactly when the granted row was already open in that bank.
- R6: The access counter of a bank is 1 after the access that opens a row and rises by one per hit. When it would reach `MAX_ACC`, the row is closed instead, so the next access to that row is a miss.
- R7: With `pick` low, or with no valid entry, no grant is produced and no bank state changes.
- R8: A grant appears in the cycle after the accepting pick, lasts exactly one cycle, names an entry that was valid when picked, and a pick seen during the grant cycle is ignored.
- R9: A granted access loads its bank's countdown with `T_HIT` for a hit or `T_MISS` for a miss. The countdown then drops by one per cycle down to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 1 | 0 = arrival order, 1 = row-hit-first |
| pick | input | 1 | Request a selection this cycle |
| req_valid | input | NQ | Per-entry valid, bit 0 oldest |
| req_rank | input | NQ*RANK_W | Per-entry rank, entry i at bits [i*RANK_W +: RANK_W] |
| req_bank | input | NQ*BSEL_W | Per-entry bank within rank, entry i at [i*BSEL_W +: BSEL_W] |
| req_row | input | NQ*ROW_W | Per-entry row, entry i at [i*ROW_W +: ROW_W] |
| grant_valid | output | 1 | One-cycle grant strobe |
| grant_idx | output | IDX_W | Index of the granted entry |
| grant_hit | output | 1 | Granted access hit the open row |
| grant_bank | output | BANK_W | Flat bank index of the granted entry |

## Verification
The assertions assume three things about the inputs:
- No request row ever equals the all-ones value reserved for a closed bank.
- The queue contents are held stable across the pick cycle.
- `pick` is kept low while reset is asserted.

The stimulus respects all three. Every row used is small, entries are driven on the falling edge before the pick and held through it, and reset is applied only with `pick` low. It also spaces its picks so that each bank's countdown is at a value worked out by hand at every selection. This makes the earliest-free case land on a known mask with two entries tied on one bank.

// File: rtl/rowhit_sel_pkg.sv
package rowhit_sel_pkg;

    typedef enum logic {
        POL_ARRIVAL = 1'b0,
        POL_ROWHIT  = 1'b1
    } sel_policy_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_GRANT = 1'b1
    } sel_state_e;

endpackage

// File: rtl/rowhit_sel_banks.sv
module rowhit_sel_banks #(
    parameter int NB      = 8,
    parameter int ROW_W   = 8,
    parameter int MAX_ACC = 3,
    parameter int T_MISS  = 6,
    parameter int T_HIT   = 2,
    parameter int BANK_W  = 3,
    parameter int BUSY_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          upd_en,
    input  logic [BANK_W-1:0]             upd_bank,
    input  logic [ROW_W-1:0]              upd_row,
    output logic [NB-1:0][ROW_W-1:0]      open_row_o,
    output logic [NB-1:0][BUSY_W-1:0]     busy_o
);
    localparam int CNT_W = $clog2(MAX_ACC + 1);
    localparam logic [ROW_W-1:0] ROW_CLOSED = '1;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [ROW_W-1:0]  row_q;
        logic [CNT_W-1:0]  cnt_q;
        logic [BUSY_W-1:0] busy_q;
        logic              sel_b;
        logic              hit_b;
        logic [CNT_W-1:0]  nxt_cnt;

        assign sel_b   = upd_en && (upd_bank == BANK_W'(b));
        assign hit_b   = (row_q == upd_row) && (row_q != ROW_CLOSED);
        assign nxt_cnt = hit_b ? cnt_q + 1'b1 : CNT_W'(1);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q  <= ROW_CLOSED;
                cnt_q  <= '0;
                busy_q <= '0;
            end else if (sel_b) begin
                busy_q <= hit_b ? BUSY_W'(T_HIT) : BUSY_W'(T_MISS);
                if (nxt_cnt >= CNT_W'(MAX_ACC)) begin
                    row_q <= ROW_CLOSED;
                    cnt_q <= '0;
                end else begin
                    row_q <= upd_row;
                    cnt_q <= nxt_cnt;
                end
            end else if (busy_q != '0) begin
                busy_q <= busy_q - 1'b1;
            end
        end

        assign open_row_o[b] = row_q;
        assign busy_o[b]     = busy_q;
    end

endmodule

// File: rtl/rowhit_sel_pick.sv
module rowhit_sel_pick #(
    parameter int NQ     = 4,
    parameter int NB     = 8,
    parameter int ROW_W  = 8,
    parameter int BANK_W = 3,
    parameter int BUSY_W = 3,
    parameter int IDX_W  = 2
) (
    input  logic                       policy,
    input  logic [NQ-1:0]              req_valid,
    input  logic [NQ-1:0][BANK_W-1:0]  ent_bank,
    input  logic [NQ-1:0][ROW_W-1:0]   ent_row,
    input  logic [NB-1:0][ROW_W-1:0]   open_row,
    input  logic [NB-1:0][BUSY_W-1:0]  busy,
    output logic                       any_o,
    output logic [IDX_W-1:0]           sel_idx_o,
    output logic                       sel_hit_o
);
    import rowhit_sel_pkg::*;

    localparam logic [ROW_W-1:0] ROW_CLOSED = '1;

    logic [NQ-1:0]     row_match;
    logic [NQ-1:0]     hit_free;
    logic [NQ-1:0]     elig;
    logic [NQ-1:0]     cand;
    logic [NB-1:0]     early_mask;
    logic [BUSY_W-1:0] min_busy;

    always_comb begin
        row_match  = '0;
        hit_free   = '0;
        elig       = '0;
        early_mask = '0;
        min_busy   = '1;
        for (int i = 0; i < NQ; i++) begin
            row_match[i] = req_valid[i]
                         && (open_row[ent_bank[i]] == ent_row[i])
                         && (open_row[ent_bank[i]] != ROW_CLOSED);
            hit_free[i]  = row_match[i] && (busy[ent_bank[i]] == '0);
            if (req_valid[i] && (busy[ent_bank[i]] < min_busy))
                min_busy = busy[ent_bank[i]];
        end
        for (int i = 0; i < NQ; i++) begin
            if (req_valid[i] && (busy[ent_bank[i]] == min_busy))
                early_mask[ent_bank[i]] = 1'b1;
        end
        for (int i = 0; i < NQ; i++) begin
            elig[i] = req_valid[i] && early_mask[ent_bank[i]];
        end
    end

    always_comb begin
        if (sel_policy_e'(policy) == POL_ARRIVAL)
            cand = req_valid;
        else if (|hit_free)
            cand = hit_free;
        else
            cand = elig;
    end

    always_comb begin
        sel_idx_o = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (cand[i]) sel_idx_o = IDX_W'(i);
        end
    end

    assign sel_hit_o = row_match[sel_idx_o];
    assign any_o     = |req_valid;

endmodule

// File: rtl/rowhit_sel.sv
module rowhit_sel
    import rowhit_sel_pkg::*;
#(
    parameter int NQ      = 4,
    parameter int RANKS   = 2,
    parameter int BPR     = 4,
    parameter int ROW_W   = 8,
    parameter int MAX_ACC = 3,
    parameter int T_MISS  = 6,
    parameter int T_HIT   = 2,
    localparam int NB     = RANKS * BPR,
    localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
    localparam int BSEL_W = (BPR > 1) ? $clog2(BPR) : 1,
    localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1,
    localparam int IDX_W  = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   policy,
    input  logic                   pick,
    input  logic [NQ-1:0]          req_valid,
    input  logic [NQ*RANK_W-1:0]   req_rank,
    input  logic [NQ*BSEL_W-1:0]   req_bank,
    input  logic [NQ*ROW_W-1:0]    req_row,
    output logic                   grant_valid,
    output logic [IDX_W-1:0]       grant_idx,
    output logic                   grant_hit,
    output logic [BANK_W-1:0]      grant_bank
);
    localparam int T_MAX  = (T_MISS > T_HIT) ? T_MISS : T_HIT;
    localparam int BUSY_W = $clog2(T_MAX + 1);

    logic [NQ-1:0][BANK_W-1:0] ent_bank;
    logic [NQ-1:0][ROW_W-1:0]  ent_row;
    logic [NB-1:0][ROW_W-1:0]  open_row;
    logic [NB-1:0][BUSY_W-1:0] busy;
    logic                      any_req;
    logic [IDX_W-1:0]          sel_idx;
    logic                      sel_hit;
    logic                      take;

    sel_state_e                state_q, state_d;
    logic [IDX_W-1:0]          idx_q;
    logic                      hit_q;
    logic [BANK_W-1:0]         bank_q;

    for (genvar i = 0; i < NQ; i++) begin : g_decode
        assign ent_bank[i] = BANK_W'(req_rank[i*RANK_W +: RANK_W]) * BANK_W'(BPR)
                           + BANK_W'(req_bank[i*BSEL_W +: BSEL_W]);
        assign ent_row[i]  = req_row[i*ROW_W +: ROW_W];
    end

    rowhit_sel_pick #(
        .NQ(NQ), .NB(NB), .ROW_W(ROW_W), .BANK_W(BANK_W),
        .BUSY_W(BUSY_W), .IDX_W(IDX_W)
    ) u_pick (
        .policy    (policy),
        .req_valid (req_valid),
        .ent_bank  (ent_bank),
        .ent_row   (ent_row),
        .open_row  (open_row),
        .busy      (busy),
        .any_o     (any_req),
        .sel_idx_o (sel_idx),
        .sel_hit_o (sel_hit)
    );

    assign take = (state_q == ST_IDLE) && pick && any_req;

    rowhit_sel_banks #(
        .NB(NB), .ROW_W(ROW_W), .MAX_ACC(MAX_ACC), .T_MISS(T_MISS),
        .T_HIT(T_HIT), .BANK_W(BANK_W), .BUSY_W(BUSY_W)
    ) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (take),
        .upd_bank   (ent_bank[sel_idx]),
        .upd_row    (ent_row[sel_idx]),
        .open_row_o (open_row),
        .busy_o     (busy)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take) state_d = ST_GRANT;
            ST_GRANT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            hit_q   <= 1'b0;
            bank_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                idx_q  <= sel_idx;
                hit_q  <= sel_hit;
                bank_q <= ent_bank[sel_idx];
            end
        end
    end

    always_comb begin
        grant_valid = (state_q == ST_GRANT);
        grant_idx   = idx_q;
        grant_hit   = hit_q && (state_q == ST_GRANT);
        grant_bank  = bank_q;
    end

endmodule

// File: rtl/rowhit_sel_chk.sv
module rowhit_sel_chk #(
    parameter int NQ    = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             policy,
    input logic             pick,
    input logic [NQ-1:0]    req_valid,
    input logic             grant_valid,
    input logic [IDX_W-1:0] grant_idx,
    input logic             grant_hit
);
    logic [NQ-1:0]    pv_q;
    logic [IDX_W-1:0] oldest;

    always_comb begin
        oldest = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (req_valid[i]) oldest = IDX_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pv_q <= '0;
        else        pv_q <= req_valid;
    end

    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !grant_valid);

    a_r8_pick_grants: assert property (@(posedge clk) disable iff (!rst_n)
        (pick && (|req_valid) && !grant_valid) |=> grant_valid);

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(pick && (|req_valid)) |=> !grant_valid);

    a_r8_valid_entry: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> pv_q[grant_idx]);

    a_r1_arrival_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        (pick && (|req_valid) && !grant_valid && !policy)
        |=> (grant_idx == $past(oldest)));

    a_r5_hit_only_granted: assert property (@(posedge clk) disable iff (!rst_n)
        grant_hit |-> grant_valid);

endmodule

bind rowhit_sel rowhit_sel_chk #(.NQ(NQ), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .policy      (policy),
    .pick        (pick),
    .req_valid   (req_valid),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .grant_hit   (grant_hit)
);

// File: tb/rowhit_sel_tb.sv
module rowhit_sel_tb;

    localparam int NQ = 4;

    typedef struct packed {
        logic       r;
        logic [1:0] b;
        logic [7:0] row;
    } ent_t;

    typedef struct packed {
        logic       pol;
        logic [3:0] v;
        ent_t       e0;
        ent_t       e1;
        ent_t       e2;
        ent_t       e3;
        logic [3:0] gap;
        logic [1:0] eidx;
        logic       ehit;
    } step_t;

    localparam ent_t NO = '{1'b0, 2'd0, 8'd0};

    // Hand-derived from R1..R9 with MAX_ACC=3, T_MISS=6, T_HIT=2, BPR=4
    localparam step_t TBL [11] = '{
        '{1'b0, 4'b1111, '{1'b0,2'd1,8'd5}, '{1'b0,2'd2,8'd7}, '{1'b0,2'd3,8'd1}, '{1'b1,2'd0,8'd2}, 4'd8, 2'd0, 1'b0},
        '{1'b1, 4'b0111, '{1'b0,2'd2,8'd3}, '{1'b0,2'd1,8'd5}, '{1'b0,2'd3,8'd1}, NO, 4'd8, 2'd1, 1'b1},
        '{1'b0, 4'b0111, '{1'b0,2'd2,8'd3}, '{1'b0,2'd1,8'd5}, '{1'b0,2'd3,8'd1}, NO, 4'd8, 2'd0, 1'b0},
        '{1'b1, 4'b0011, '{1'b0,2'd1,8'd5}, '{1'b1,2'd1,8'd9}, NO, NO, 4'd8, 2'd0, 1'b1},
        '{1'b1, 4'b0010, NO, '{1'b0,2'd1,8'd5}, NO, NO, 4'd8, 2'd1, 1'b0},
        '{1'b1, 4'b0001, '{1'b1,2'd1,8'd5}, NO, NO, NO, 4'd2, 2'd0, 1'b0},
        '{1'b1, 4'b0011, '{1'b1,2'd1,8'd5}, '{1'b0,2'd1,8'd5}, NO, NO, 4'd1, 2'd1, 1'b1},
        '{1'b1, 4'b0111, '{1'b1,2'd1,8'd9}, '{1'b0,2'd1,8'd6}, '{1'b0,2'd1,8'd5}, NO, 4'd8, 2'd1, 1'b0},
        '{1'b1, 4'b1100, NO, NO, '{1'b0,2'd1,8'd6}, '{1'b0,2'd2,8'd3}, 4'd8, 2'd2, 1'b1},
        '{1'b0, 4'b1000, NO, NO, NO, '{1'b0,2'd2,8'd3}, 4'd8, 2'd3, 1'b1},
        '{1'b1, 4'b0001, '{1'b0,2'd1,8'd6}, NO, NO, NO, 4'd8, 2'd0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          policy = 1'b0;
    logic          pick = 1'b0;
    logic [NQ-1:0] req_valid = '0;
    logic [NQ-1:0] req_rank = '0;
    logic [2*NQ-1:0] req_bank = '0;
    logic [8*NQ-1:0] req_row = '0;
    logic          grant_valid;
    logic [1:0]    grant_idx;
    logic          grant_hit;
    logic [2:0]    grant_bank;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rowhit_sel u_dut (
        .clk(clk), .rst_n(rst_n), .policy(policy), .pick(pick),
        .req_valid(req_valid), .req_rank(req_rank), .req_bank(req_bank),
        .req_row(req_row), .grant_valid(grant_valid), .grant_idx(grant_idx),
        .grant_hit(grant_hit), .grant_bank(grant_bank)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input step_t s);
        policy    = s.pol;
        req_valid = s.v;
        req_rank  = {s.e3.r, s.e2.r, s.e1.r, s.e0.r};
        req_bank  = {s.e3.b, s.e2.b, s.e1.b, s.e0.b};
        req_row   = {s.e3.row, s.e2.row, s.e1.row, s.e0.row};
    endtask

    function automatic int flat_of(input step_t s, input int i);
        ent_t e;
        case (i)
            0: e = s.e0;
            1: e = s.e1;
            2: e = s.e2;
            default: e = s.e3;
        endcase
        return int'(e.r) * 4 + int'(e.b);
    endfunction

    // pick captured at next posedge; grant visible at the negedge after it
    task automatic run(input step_t s, input string tag);
        @(negedge clk);
        drive(s);
        pick = 1'b1;
        @(negedge clk);
        pick = 1'b0;
        check({tag, " valid"}, int'(grant_valid), 1);
        check({tag, " idx"},   int'(grant_idx),   int'(s.eidx));
        check({tag, " hit"},   int'(grant_hit),   int'(s.ehit));
        check({tag, " R4 bank"}, int'(grant_bank), flat_of(s, int'(s.eidx)));
        repeat (int'(s.gap)) @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step_t s;
        repeat (3) @(negedge clk);
        check("R5 reset grant_valid", int'(grant_valid), 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6 R9 table walk
        for (int k = 0; k < 11; k++) begin
            run(TBL[k], $sformatf("R1/R2/R3/R6/R9 step%0d", k));
        end

        // R7: empty queue with pick held, no grant
        @(negedge clk);
        req_valid = '0;
        pick = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R7 empty queue", int'(grant_valid), 0);
        end
        // R7: valid entries but pick low, no grant
        pick = 1'b0;
        s = '{1'b1, 4'b0001, '{1'b0,2'd2,8'd3}, NO, NO, NO, 4'd8, 2'd0, 1'b1};
        drive(s);
        repeat (3) begin
            @(negedge clk);
            check("R7 pick low", int'(grant_valid), 0);
        end
        // bank2 row3 still holds count 2: hit, then closes (R7 state kept, R6)
        run(s, "R7 state kept");
        s.ehit = 1'b0;
        run(s, "R6 closed after max");

        // R8: pick held across the grant cycle is ignored there
        @(negedge clk);
        s = '{1'b0, 4'b0100, NO, NO, '{1'b0,2'd3,8'd4}, NO, 4'd1, 2'd2, 1'b0};
        drive(s);
        pick = 1'b1;
        @(negedge clk);
        check("R8 grant idx", int'(grant_idx), 2);
        check("R8 grant on", int'(grant_valid), 1);
        @(negedge clk);
        pick = 1'b0;
        check("R8 one cycle", int'(grant_valid), 0);
        @(negedge clk);
        check("R8 pick in grant ignored", int'(grant_valid), 0);

        // R5: reset closes all rows
        repeat (8) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R5 reset mid-run", int'(grant_valid), 0);
        rst_n = 1'b1;
        s = '{1'b1, 4'b0001, '{1'b0,2'd3,8'd4}, NO, NO, NO, 4'd2, 2'd0, 1'b0};
        run(s, "R5 closed after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule